// File: doc/BRIEF.md
# Multi-Mode Transmit Write Packer

This block sits between a 32-bit register write port and the transmit FIFO of a serial controller. The controller can run as a byte-oriented asynchronous or infrared port, as a codec port with 8, 16, 24 or 32-bit samples, or as an AC97 link. Each register write carries a data word, a size code and the active mode. The packer checks that the size is legal for the mode. It then breaks the word into one or more FIFO entries in a fixed order. In AC97 mode it also attaches a start-of-frame flag to each entry.

Bits are numbered MSB-0 at the register level: bit 0 of the write word is `wr_data[31]`. Bytes that sit at lower-numbered positions leave first, so the most significant byte leaves first. Entries are right-justified in `fifo_data`, and the unused upper bits are zero. A write that needs several entries holds `wr_ready` low until the FIFO has taken every entry. A full FIFO stalls the packer, and no data is lost.

Mode codes on `mode`: 0 byte (UART, IrDA, 8-bit codec), 1 codec16, 2 codec24, 3 codec32, 4 AC97 normal, 5 AC97 enhanced. Codes 6 and 7 are unused. Size codes on `wr_size`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = never legal.

Top module: `tx_write_packer`

## Requirements
- R1: After reset, `wr_ready` is 1, `fifo_valid` is 0 and `wr_err` is 0.
- R2: In mode 0, a 1-byte write pushes `wr_data[31:24]`. A 2-byte write pushes `wr_data[31:24]` and then `wr_data[23:16]`. A 4-byte write pushes the four bytes from `wr_data[31:24]` down to `wr_data[7:0]`. Each entry sits in `fifo_data[7:0]`, and the upper bits are zero.
- R3: In mode 1, a 2-byte write pushes `wr_data[31:16]`. A 4-byte write pushes `wr_data[31:16]` and then `wr_data[15:0]`. Each entry sits in `fifo_data[15:0]`. A 1-byte write is illegal.
- R4: In mode 2, a 4-byte write pushes one entry `{8'h00, wr_data[23:0]}`. Any other size is illegal.
- R5: In mode 3, a 4-byte write pushes `wr_data` unchanged as one entry. Any other size is illegal.
- R6: In mode 4, a 4-byte write pushes one entry. That entry has `fifo_data[19:0]` = `wr_data[31:12]` (MSB-0 bits 0:19) and `fifo_sof` = `wr_data[11]` (MSB-0 bit 20). `wr_data[10:0]` has no effect.
- R7: In mode 5, a 4-byte write pushes one entry with `fifo_data[19:0]` = `wr_data[19:0]` and `fifo_sof` = 0. `fifo_sof` is 0 in every mode other than mode 4.
- R8: An illegal size, or a mode code of 6 or 7, pushes nothing. `wr_err` is then 1 for exactly the one cycle after the accepting clock edge.
- R9: After a legal write is accepted, `fifo_valid` is 1 from the next cycle onward. `wr_ready` stays 0 until the FIFO has accepted the last entry. Changes on `mode`, `wr_size` and `wr_data` during that time have no effect.
- R10: While `fifo_valid` is 1 and `fifo_ready` is 0, `fifo_valid`, `fifo_data` and `fifo_sof` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Active mode code |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Packer can accept a write |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write word, MSB-0 bit 0 on bit 31 |
| wr_err | output | 1 | One-cycle illegal-size pulse |
| fifo_valid | output | 1 | Entry present for the FIFO |
| fifo_ready | input | 1 | FIFO accepts the entry |
| fifo_data | output | 32 | Right-justified entry |
| fifo_sof | output | 1 | AC97 start-of-frame flag for the entry |

## Verification
The bench builds the block with its default AC97 sample width of 20. It drives every mode with every size code, including the unused codes. When the bench holds `fifo_ready` low in a repeating pattern, the FIFO stalls in the middle of a four-entry byte write. Each write is followed by changes on the mode, size and data inputs, which shows that these inputs are latched. The AC97 words are chosen so that the start-of-frame bit and the ignored low bits differ from one write to the next.

// File: rtl/tx_write_packer.sv
module tx_write_packer #(
  parameter int AW = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [1:0]  wr_size,
  input  logic [31:0] wr_data,
  output logic        wr_err,
  output logic        fifo_valid,
  input  logic        fifo_ready,
  output logic [31:0] fifo_data,
  output logic        fifo_sof
);
  localparam logic [2:0] M_BYTE = 3'd0, M_C16 = 3'd1, M_C24 = 3'd2,
                         M_C32 = 3'd3, M_AC97 = 3'd4, M_ENH = 3'd5;
  localparam int SOF_BIT = 31 - AW;

  logic [31:0] word_q;
  logic [2:0]  mode_q;
  logic [2:0]  left_q;
  logic        err_q;
  logic        legal;
  logic [2:0]  n_ent;

  wire accept = wr_valid && wr_ready;
  wire pop    = fifo_valid && fifo_ready;

  assign fifo_valid = left_q != 3'd0;
  assign wr_ready   = left_q == 3'd0;
  assign wr_err     = err_q;

  always_comb begin
    legal = 1'b0;
    n_ent = 3'd1;
    case (mode)
      M_BYTE: begin
        legal = wr_size != 2'd3;
        n_ent = (wr_size == 2'd0) ? 3'd1 : (wr_size == 2'd1) ? 3'd2 : 3'd4;
      end
      M_C16: begin
        legal = (wr_size == 2'd1) || (wr_size == 2'd2);
        n_ent = (wr_size == 2'd2) ? 3'd2 : 3'd1;
      end
      M_C24, M_C32, M_AC97, M_ENH: legal = wr_size == 2'd2;
      default: legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      mode_q <= M_BYTE;
      left_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && !legal;
      if (accept && legal) begin
        word_q <= wr_data;
        mode_q <= mode;
        left_q <= n_ent;
      end else if (pop) begin
        left_q <= left_q - 3'd1;
        word_q <= (mode_q == M_BYTE) ? {word_q[23:0], 8'h00} : {word_q[15:0], 16'h0000};
      end
    end
  end

  always_comb begin
    fifo_data = '0;
    fifo_sof  = 1'b0;
    case (mode_q)
      M_BYTE:  fifo_data[7:0]  = word_q[31:24];
      M_C16:   fifo_data[15:0] = word_q[31:16];
      M_C24:   fifo_data[23:0] = word_q[23:0];
      M_C32:   fifo_data       = word_q;
      M_AC97: begin
        fifo_data[AW-1:0] = word_q[31:32-AW];
        fifo_sof          = word_q[SOF_BIT];
      end
      M_ENH:   fifo_data[AW-1:0] = word_q[AW-1:0];
      default: fifo_data = '0;
    endcase
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid && !fifo_ready |=> fifo_valid && $stable(fifo_data) && $stable(fifo_sof));

  p_err_nopush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> !fifo_valid && wr_ready);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_valid && wr_ready));

  p_push_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && legal |=> fifo_valid && !wr_ready);

  p_sof_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_sof |-> fifo_valid && fifo_data[31:AW] == '0);

  p_byte_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid && mode_q == M_BYTE |-> fifo_data[31:8] == 24'h0);
endmodule

// File: tb/tb_tx_write_packer.sv
module tb_tx_write_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic        wr_err;
  logic        fifo_valid;
  logic        fifo_ready = 1'b1;
  logic [31:0] fifo_data;
  logic        fifo_sof;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  tx_write_packer dut (.*);

  function automatic void chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic send(input string req, input logic [2:0] m, input logic [1:0] s, input logic [31:0] d,
                      input bit stall, input int n_exp,
                      input logic [32:0] e0, input logic [32:0] e1, input logic [32:0] e2, input logic [32:0] e3);
    logic [32:0] exp [4];
    logic [32:0] got [4];
    logic [32:0] held;
    bit have_held;
    int n;
    exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
    n = 0; have_held = 0; held = '0;
    @(negedge clk);
    mode = m; wr_size = s; wr_data = d; wr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; mode = 3'd3; wr_size = 2'd0; wr_data = ~d;
    chk(wr_err == (n_exp == 0), {req, " err pulse (R8)"}, {32'h0, wr_err}, {32'h0, n_exp == 0});
    chk(fifo_valid == (n_exp != 0), {req, " valid after accept (R9)"}, {32'h0, fifo_valid}, {32'h0, n_exp != 0});
    for (int i = 0; i < 16; i++) begin
      fifo_ready = stall ? (i % 3 == 2) : 1'b1;
      #1;
      if (have_held)
        chk(fifo_valid && {fifo_sof, fifo_data} == held, {req, " hold under stall (R10)"}, {fifo_sof, fifo_data}, held);
      have_held = 0;
      if (fifo_valid) begin
        if (wr_ready) chk(1'b0, {req, " ready low while busy (R9)"}, 33'h1, 33'h0);
        if (fifo_ready) begin
          if (n < 4) got[n] = {fifo_sof, fifo_data};
          n++;
        end else begin
          held = {fifo_sof, fifo_data};
          have_held = 1;
        end
      end
      if (i > 0 && i < 15 && i % 2 == 1) mode = 3'(i);
      @(negedge clk);
    end
    fifo_ready = 1'b1;
    chk(n == n_exp, {req, " entry count"}, 33'(n), 33'(n_exp));
    for (int k = 0; k < 4; k++)
      if (k < n_exp && k < n) chk(got[k] == exp[k], {req, " entry"}, got[k], exp[k]);
    chk(wr_ready && !wr_err, {req, " idle after write (R9)"}, {31'h0, wr_ready, wr_err}, 33'h2);
  endtask

  task automatic t_reset();
    #1;
    chk(wr_ready == 1'b1, "R1 ready", {32'h0, wr_ready}, 33'h1);
    chk(fifo_valid == 1'b0, "R1 valid", {32'h0, fifo_valid}, 33'h0);
    chk(wr_err == 1'b0, "R1 err", {32'h0, wr_err}, 33'h0);
  endtask

  task automatic t_byte();
    send("R2 4B", 3'd0, 2'd2, 32'hA1B2C3D4, 0, 4, 33'hA1, 33'hB2, 33'hC3, 33'hD4);
    send("R2 2B", 3'd0, 2'd1, 32'hA1B2C3D4, 0, 2, 33'hA1, 33'hB2, 0, 0);
    send("R2 1B", 3'd0, 2'd0, 32'h5A000000, 0, 1, 33'h5A, 0, 0, 0);
  endtask

  task automatic t_c16();
    send("R3 4B", 3'd1, 2'd2, 32'hA1B2C3D4, 0, 2, 33'hA1B2, 33'hC3D4, 0, 0);
    send("R3 2B", 3'd1, 2'd1, 32'hBEEF1234, 0, 1, 33'hBEEF, 0, 0, 0);
    send("R3 1B illegal", 3'd1, 2'd0, 32'hA1B2C3D4, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_c24_c32();
    send("R4 4B", 3'd2, 2'd2, 32'hA1B2C3D4, 0, 1, 33'h00B2C3D4, 0, 0, 0);
    send("R4 2B illegal", 3'd2, 2'd1, 32'hA1B2C3D4, 0, 0, 0, 0, 0, 0);
    send("R5 4B", 3'd3, 2'd2, 32'hA1B2C3D4, 0, 1, 33'hA1B2C3D4, 0, 0, 0);
    send("R5 1B illegal", 3'd3, 2'd0, 32'hA1B2C3D4, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_ac97();
    send("R6 sof set", 3'd4, 2'd2, 32'h12345800, 0, 1, {1'b1, 32'h00012345}, 0, 0, 0);
    send("R6 sof clear", 3'd4, 2'd2, 32'h123457FF, 0, 1, {1'b0, 32'h00012345}, 0, 0, 0);
    send("R7 enhanced", 3'd5, 2'd2, 32'hFFFABCDE, 0, 1, {1'b0, 32'h000ABCDE}, 0, 0, 0);
  endtask

  task automatic t_illegal();
    send("R8 size3", 3'd0, 2'd3, 32'hA1B2C3D4, 0, 0, 0, 0, 0, 0);
    send("R8 mode6", 3'd6, 2'd2, 32'hA1B2C3D4, 0, 0, 0, 0, 0, 0);
    send("R8 mode7", 3'd7, 2'd0, 32'hA1B2C3D4, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_stall();
    send("R10 byte stall", 3'd0, 2'd2, 32'h0F1E2D3C, 1, 4, 33'h0F, 33'h1E, 33'h2D, 33'h3C);
    send("R10 c16 stall", 3'd1, 2'd2, 32'h13579BDF, 1, 2, 33'h1357, 33'h9BDF, 0, 0);
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_byte();
    t_c16();
    t_c24_c32();
    t_ac97();
    t_illegal();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule